// File: doc/BRIEF.md
# Prefetch Halfword Queue

This block buffers instruction halfwords that have been prefetched for a decoder. The bus side delivers 32-bit double words. The decoder side always sees the oldest 16-bit halfword at the head, and it removes that halfword once it has been decoded. Storage is a five-entry first-in-first-out array. Each accepted double word lands directly in the two slots that follow the current occupancy, low half first.

An execution core keeps its own copy of the same queue, so the two must stay in step. It sends commands over two control lines that are time-multiplexed across a two-cycle frame. The frame encodes four commands: idle, fetch-issued, discard one halfword and flush. A fetch-issued command grants one write credit, and the bus side writes only while a credit is held. Discard drops the head halfword, which the core consumed as displacement or immediate data. Flush empties the queue.

Top module: `hw_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`head_valid` low), holds no write credit (`wr_ready` low), and the first cycle after reset release is command phase A.
- R2: Occupancy never exceeds DEPTH (5). An accepted double word puts bits [15:0] in the slot nearer the head and bits [31:16] right behind it.
- R3: `wr_ready` is high exactly when at least one credit is held and at least two slots are free. A write presented while `wr_ready` is low is ignored.
- R4: A fetch-issued command adds one credit, saturating at MAX_CREDIT (3). Each accepted write uses one credit, and a write and a fetch in the same cycle leave the credit count unchanged.
- R5: `head_data` is the oldest stored halfword and `head_valid` is high exactly when the queue is non-empty. With no removal, the head stays unchanged.
- R6: `pop` removes the head halfword. A `pop` on an empty queue is ignored.
- R7: Phases alternate A, B, A, ... from reset. In phase A, `ctl_line[1]` gives code bit 1. In phase B, `ctl_line[0]` gives code bit 0. The other line in each phase is ignored. The codes are 00 idle, 01 fetch-issued, 10 discard, 11 flush. A command takes effect at the clock edge that ends the cycle following its phase B.
- R8: Discard removes one halfword from the head. When it coincides with `pop`, two halfwords are removed, limited to the current occupancy.
- R9: Flush empties the queue and clears all credits, and it overrides a write or a `pop` in the same cycle.
- R10: A `pop` and an accepted write in the same cycle both take effect. `wr_ready` is judged on the occupancy before the `pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_line | input | 2 | Time-multiplexed command lines from the execution core |
| wr_valid | input | 1 | Bus side offers a fetched double word |
| wr_data | input | 32 | Fetched double word, low halfword first in order |
| wr_ready | output | 1 | Write will be accepted this cycle |
| pop | input | 1 | Decoder consumed the head halfword |
| head_valid | output | 1 | Queue holds at least one halfword |
| head_data | output | 16 | Oldest halfword |

## Verification
The bench uses the default parameters: DEPTH 5, 16-bit halfwords and MAX_CREDIT 3. Because the depth is odd, the queue can sit at four entries with one slot free, and there a write must stall even though room is left. A credit limit of three lets four back-to-back fetch commands show saturation within a few frames. Random command lines, often carrying flushes and discards, drive the queue through empty, near-full and same-cycle pop-plus-discard cases that the directed sequences set up only once.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    // Command codes carried by the two multiplexed control lines.
    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_FETCH   = 2'b01,
        CMD_DISCARD = 2'b10,
        CMD_FLUSH   = 2'b11
    } pfq_cmd_e;
endpackage

// File: rtl/pfq_cmd_rx.sv
module pfq_cmd_rx
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_line,
    output pfq_cmd_e   cmd
);
    typedef struct packed {
        logic     phase_b;
        logic     hi_bit;
        pfq_cmd_e cmd;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.phase_b = ~st_q.phase_b;
        st_d.cmd     = CMD_IDLE;
        if (!st_q.phase_b) begin
            st_d.hi_bit = ctl_line[1];
        end else begin
            st_d.cmd = pfq_cmd_e'({st_q.hi_bit, ctl_line[0]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase_b: 1'b0, hi_bit: 1'b0, cmd: CMD_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd = st_q.cmd;
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH      = 5,
    parameter int MAX_CREDIT = 3,
    parameter int CNT_W      = $clog2(DEPTH + 1),
    parameter int CRED_W     = $clog2(MAX_CREDIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pfq_cmd_e         cmd,
    input  logic             wr_valid,
    input  logic             pop,
    output logic             wr_ready,
    output logic             wr_take,
    output logic             flush,
    output logic [1:0]       rm_cnt,
    output logic [CNT_W-1:0] count,
    output logic             head_valid
);
    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CRED_W-1:0] cred;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic [1:0]  req;
    int          cred_tmp;

    always_comb begin
        st_d     = st_q;
        flush    = (cmd == CMD_FLUSH);
        wr_ready = (st_q.cred != '0) && (int'(st_q.count) + 2 <= DEPTH);
        wr_take  = wr_valid && wr_ready && !flush;
        req      = {1'b0, pop} + {1'b0, cmd == CMD_DISCARD};
        rm_cnt   = req;
        if (int'(req) > int'(st_q.count)) begin
            rm_cnt = 2'(st_q.count);
        end
        cred_tmp = int'(st_q.cred) - (wr_take ? 1 : 0) + ((cmd == CMD_FETCH) ? 1 : 0);
        if (cred_tmp > MAX_CREDIT) begin
            cred_tmp = MAX_CREDIT;
        end
        if (flush) begin
            rm_cnt     = 2'b00;
            st_d.count = '0;
            st_d.cred  = '0;
        end else begin
            st_d.count = CNT_W'(int'(st_q.count) - int'(rm_cnt) + (wr_take ? 2 : 0));
            st_d.cred  = CRED_W'(cred_tmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.count;
    assign head_valid = (st_q.count != '0);
endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 5,
    parameter int HW_W  = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        rm_cnt,
    input  logic              wr_take,
    input  logic              flush,
    input  logic [2*HW_W-1:0] wr_data,
    output logic [HW_W-1:0]   head_data
);
    logic [HW_W-1:0]  slot_q [DEPTH];
    logic [HW_W-1:0]  slot_d [DEPTH];
    logic [CNT_W-1:0] wr_base;

    // Slot index that receives the low halfword after this cycle's removals.
    assign wr_base = count - CNT_W'(rm_cnt);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = '0;
            if (!flush) begin
                for (int s = 0; s < DEPTH; s++) begin
                    if (s == g + int'(rm_cnt)) begin
                        slot_d[g] = slot_q[s];
                    end
                end
                if (wr_take && (int'(wr_base) == g)) begin
                    slot_d[g] = wr_data[HW_W-1:0];
                end
                if (wr_take && (int'(wr_base) + 1 == g)) begin
                    slot_d[g] = wr_data[2*HW_W-1:HW_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign head_data = slot_q[0];
endmodule

// File: rtl/hw_prefetch_queue.sv
module hw_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH      = 5,
    parameter int HW_W       = 16,
    parameter int MAX_CREDIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_line,
    input  logic              wr_valid,
    input  logic [2*HW_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              pop,
    output logic              head_valid,
    output logic [HW_W-1:0]   head_data
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CRED_W = $clog2(MAX_CREDIT + 1);

    pfq_cmd_e         cmd_w;
    logic             wr_take_w;
    logic             flush_w;
    logic [1:0]       rm_w;
    logic [CNT_W-1:0] count_w;

    pfq_cmd_rx u_cmd_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_line (ctl_line),
        .cmd      (cmd_w)
    );

    pfq_ctrl #(
        .DEPTH      (DEPTH),
        .MAX_CREDIT (MAX_CREDIT),
        .CNT_W      (CNT_W),
        .CRED_W     (CRED_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_w),
        .wr_valid   (wr_valid),
        .pop        (pop),
        .wr_ready   (wr_ready),
        .wr_take    (wr_take_w),
        .flush      (flush_w),
        .rm_cnt     (rm_w),
        .count      (count_w),
        .head_valid (head_valid)
    );

    pfq_store #(
        .DEPTH (DEPTH),
        .HW_W  (HW_W),
        .CNT_W (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count_w),
        .rm_cnt    (rm_w),
        .wr_take   (wr_take_w),
        .flush     (flush_w),
        .wr_data   (wr_data),
        .head_data (head_data)
    );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int HW_W  = 16,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pop,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             head_valid,
    input logic [HW_W-1:0]  head_data,
    input pfq_cmd_e         cmd,
    input logic [CNT_W-1:0] count
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    assert_ready_needs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (int'(count) + 2 <= DEPTH));

    assert_head_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop && cmd != CMD_DISCARD && cmd != CMD_FLUSH)
        |=> (head_valid && $stable(head_data)));

    assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && !(wr_valid && wr_ready)) |=> !head_valid);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_FLUSH) |=> (!head_valid && !wr_ready));

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && cmd != CMD_FLUSH) |=> head_valid);
endmodule

bind hw_prefetch_queue pfq_checker #(
    .DEPTH (DEPTH),
    .HW_W  (HW_W),
    .CNT_W (CNT_W)
) u_pfq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop        (pop),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .head_valid (head_valid),
    .head_data  (head_data),
    .cmd        (cmd_w),
    .count      (count_w)
);

// File: tb/hw_prefetch_queue_bench.sv
`timescale 1ns/1ps
module hw_prefetch_queue_bench;
    localparam int DEPTH      = 5;
    localparam int HW_W       = 16;
    localparam int MAX_CREDIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctl_line = 2'b00;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        pop = 1'b0;
    logic        head_valid;
    logic [15:0] head_data;

    always #4 clk = ~clk;

    hw_prefetch_queue #(
        .DEPTH      (DEPTH),
        .HW_W       (HW_W),
        .MAX_CREDIT (MAX_CREDIT)
    ) u_hw_prefetch_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_line   (ctl_line),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .pop        (pop),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Reference state derived from the requirements.
    logic [15:0] m_q [DEPTH];
    int          m_cnt   = 0;
    int          m_cred  = 0;
    bit          m_phb   = 0;
    bit          m_hi    = 0;
    int          m_cmd   = 0;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_edge(logic [1:0] cl, bit wv, logic [31:0] wd, bit pp);
        bit ready = (m_cred > 0) && (m_cnt + 2 <= DEPTH);
        bit take  = wv && ready;
        int rm;
        if (m_cmd == 3) begin
            m_cnt  = 0;
            m_cred = 0;
        end else begin
            rm = (pp ? 1 : 0) + ((m_cmd == 2) ? 1 : 0);
            if (rm > m_cnt) rm = m_cnt;
            for (int i = 0; i < DEPTH; i++) begin
                if (i + rm < DEPTH) m_q[i] = m_q[i + rm];
            end
            m_cnt = m_cnt - rm;
            if (take) begin
                m_q[m_cnt]     = wd[15:0];
                m_q[m_cnt + 1] = wd[31:16];
                m_cnt += 2;
            end
            m_cred = m_cred - (take ? 1 : 0) + ((m_cmd == 1) ? 1 : 0);
            if (m_cred > MAX_CREDIT) m_cred = MAX_CREDIT;
        end
        if (m_phb) begin
            m_cmd = {30'd0, m_hi, cl[0]};
        end else begin
            m_hi  = cl[1];
            m_cmd = 0;
        end
        m_phb = !m_phb;
    endfunction

    // One clock: drive at falling edge, advance model at rising edge, compare at next falling edge.
    task automatic step(logic [1:0] cl, bit wv, logic [31:0] wd, bit pp);
        ctl_line = cl;
        wr_valid = wv;
        wr_data  = wd;
        pop      = pp;
        @(posedge clk);
        model_edge(cl, wv, wd, pp);
        @(negedge clk);
        check("R3", "wr_ready", 32'(wr_ready), 32'((m_cred > 0) && (m_cnt + 2 <= DEPTH)));
        check("R5", "head_valid", 32'(head_valid), 32'(m_cnt != 0));
        if (m_cnt != 0) check("R5", "head_data", 32'(head_data), 32'(m_q[0]));
    endtask

    task automatic idle();
        step(2'b00, 1'b0, 32'h0, 1'b0);
    endtask

    // Sends a command frame; unused line in each phase carries junk (R7).
    task automatic send_cmd(logic [1:0] code);
        if (m_phb) idle();
        step({code[1], 1'b1}, 1'b0, 32'h0, 1'b0);
        step({1'b1, code[0]}, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
        repeat (3) @(negedge clk);
        check("R1", "reset head_valid", 32'(head_valid), 32'h0);
        check("R1", "reset wr_ready", 32'(wr_ready), 32'h0);
        rst_n = 1'b1;

        // R3: write without credit ignored
        step(2'b00, 1'b1, 32'hDEAD_BEEF, 1'b0);
        check("R3", "no-credit write", 32'(head_valid), 32'h0);

        // R7: fetch frame, effect one cycle after phase B
        send_cmd(2'b01);
        check("R7", "before effect", 32'(wr_ready), 32'h0);
        idle();
        check("R4", "credit granted", 32'(wr_ready), 32'h1);

        // R2: low halfword first
        step(2'b00, 1'b1, 32'h2222_1111, 1'b0);
        check("R2", "low half at head", 32'(head_data), 32'h1111);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R6", "pop shows high half", 32'(head_data), 32'h2222);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R6", "empty after pops", 32'(head_valid), 32'h0);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R6", "pop on empty", 32'(head_valid), 32'h0);

        // R4: saturation at three credits
        for (int k = 0; k < 4; k++) send_cmd(2'b01);
        idle();
        step(2'b00, 1'b1, 32'h0B0B_0A0A, 1'b0);
        step(2'b00, 1'b1, 32'h0D0D_0C0C, 1'b0);
        check("R3", "one free slot stalls", 32'(wr_ready), 32'h0);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R10", "ready after pop", 32'(wr_ready), 32'h1);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R5", "head order", 32'(head_data), 32'h0C0C);
        step(2'b00, 1'b1, 32'h0F0F_0E0E, 1'b0);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R4", "credits saturated at max", 32'(wr_ready), 32'h0);
        check("R4", "head", 32'(head_data), 32'h0E0E);

        // R8: discard alone, then with pop
        send_cmd(2'b10);
        idle();
        check("R8", "discard one", 32'(head_data), 32'h0F0F);
        send_cmd(2'b01);
        idle();
        step(2'b00, 1'b1, 32'h6666_5555, 1'b0);
        send_cmd(2'b10);
        step(2'b00, 1'b0, 32'h0, 1'b1);
        check("R8", "discard plus pop", 32'(head_data), 32'h6666);

        // R10: pop and write together
        send_cmd(2'b01);
        idle();
        step(2'b00, 1'b1, 32'h8888_7777, 1'b1);
        check("R10", "pop+write head", 32'(head_data), 32'h7777);

        // R9: flush overrides write and pop
        send_cmd(2'b01);
        idle();
        send_cmd(2'b11);
        step(2'b00, 1'b1, 32'h1234_5678, 1'b1);
        check("R9", "flush empties", 32'(head_valid), 32'h0);
        check("R9", "flush clears credit", 32'(wr_ready), 32'h0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] cl;
            cl[1] = (($urandom % 5) == 0);
            cl[0] = $urandom % 2;
            step(cl, (($urandom % 3) != 0), $urandom, $urandom % 2);
        end

        summary();
        $finish;
    end
endmodule